// File: doc/BRIEF.md
# Video Display Completion Notification Controller

This block sits beside the output timing of a video display port and tells the host when display work for a field or a frame has finished. A small mode selection picks one of several operations. In continuous operation the fields stream out with no host involvement. In the other operations a chosen field-end event latches a done flag, and the host must clear that flag before a deadline. The block follows which field is being output and gives a per-field transfer enable. Where that enable is high, DMA requests are made. Where it is low, the port keeps its full timing but sends default pixel data.

The mode is formed from three controls: `cont_en`, `frame_sel` and the two-bit `fld_sel`. In `fld_sel`, bit 0 stands for field 1 and bit 1 stands for field 2. Every time a done flag is set, `cmpl_irq` pulses. If the host misses a deadline, `miss_irq` pulses. The done flag stays set in that case, and transfers carry on as normal. The host clears each flag with a one-cycle write-one-to-clear pulse.

A three-state machine tracks the field position. It starts in ST_BLANK. A field-1 start strobe moves it to ST_FLD1 and a field-2 start strobe moves it to ST_FLD2, from any state. A field-end strobe returns it to ST_BLANK. If a start and an end arrive in the same cycle, the start wins.

Top module: `vid_done_notify`

## Requirements
- R1: While reset is asserted and right after it is released, all three done flags, both interrupts and `xfer_en` are 0.
- R2: With `cont_en`=1, no done flag is set and neither interrupt fires, whatever the other controls are. `xfer_en` is 1 during both fields.
- R3: With `cont_en`=0, `frame_sel`=0 and `fld_sel`=01, only field 1 is transferred. A `f1_end` strobe sets `f1_done` one cycle later.
- R4: With `cont_en`=0, `frame_sel`=0 and `fld_sel`=10, only field 2 is transferred. A `f2_end` strobe sets `f2_done` one cycle later.
- R5: With `cont_en`=0, `frame_sel`=0 and `fld_sel`=11, both fields are transferred. `f1_end` sets `f1_done` and `f2_end` sets `f2_done`, each one cycle later.
- R6: With `cont_en`=0, `frame_sel`=1 and `fld_sel`=00, both fields are transferred. `f2_end` sets `frm_done` one cycle later.
- R7: With `cont_en`=0, `frame_sel`=1 and `fld_sel`=01 (progressive), only field 1 is transferred. `f1_end` sets `frm_done` one cycle later.
- R8: The reserved selections are `cont_en`=0 with `frame_sel`=0 and `fld_sel`=00, and `cont_en`=0 with `frame_sel`=1 and `fld_sel` of 10 or 11. In these selections no flag is set, no interrupt fires and `xfer_en` stays 0.
- R9: `cmpl_irq` is a one-cycle pulse. It is high in exactly the cycle in which a done flag is newly set or set again.
- R10: In the R3, R4 and R5 operations, a start strobe for a field whose done flag is still set, with no clear pulse for that flag in the same cycle, makes `miss_irq` pulse one cycle later. The flag stays set.
- R11: In the R6 and R7 operations, a frame-completing end strobe while `frm_done` is still set, with no `ack_frm` in the same cycle, makes `miss_irq` pulse one cycle later. The flag stays set.
- R12: An `ack_*` pulse clears its flag one cycle later. If a set event and a clear pulse for the same flag fall in the same cycle, the flag ends up set. A clear pulse given alongside a deadline event prevents the miss.
- R13: `xfer_en` is 0 in ST_BLANK. In ST_FLD1 or ST_FLD2 it equals the field's enable in the current operation, whether or not any done flag is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cont_en | input | 1 | Continuous operation, no host interaction |
| frame_sel | input | 1 | Frame-based completion instead of field-based |
| fld_sel | input | 2 | Field selection, bit 0 field 1, bit 1 field 2 |
| f1_start | input | 1 | Field 1 begins (strobe) |
| f1_end | input | 1 | Field 1 display finished (strobe) |
| f2_start | input | 1 | Field 2 begins (strobe) |
| f2_end | input | 1 | Field 2 display finished (strobe) |
| ack_f1 | input | 1 | Write-one-to-clear pulse for f1_done |
| ack_f2 | input | 1 | Write-one-to-clear pulse for f2_done |
| ack_frm | input | 1 | Write-one-to-clear pulse for frm_done |
| f1_done | output | 1 | Field 1 done flag |
| f2_done | output | 1 | Field 2 done flag |
| frm_done | output | 1 | Frame done flag |
| cmpl_irq | output | 1 | Display-complete interrupt pulse |
| miss_irq | output | 1 | Not-acknowledged interrupt pulse |
| xfer_en | output | 1 | Current field uses DMA data (0 means default data) |

## Verification
Two things can meet in one cycle: a host clear and a flag set, or a host clear and a deadline check. The bench walks through all sixteen control settings. For each one it runs two frames with no clearing, then repeats the end strobes and start strobes with the matching `ack_*` pulse in the same cycle. A reference model built from the requirements predicts the results. Where the two meet, the flag should stay set and no miss should occur, and each output is compared against the model one cycle after every stimulus.

// File: rtl/vdn_pkg.sv
package vdn_pkg;

    localparam int NFLAG   = 3;
    localparam int SEL_W   = 2;
    localparam int IDX_F1  = 0;
    localparam int IDX_F2  = 1;
    localparam int IDX_FRM = 2;

    // Decoded display operation
    typedef enum logic [2:0] {
        MD_CONT,
        MD_FLD1,
        MD_FLD2,
        MD_BOTH,
        MD_FRAME,
        MD_PROG,
        MD_RSVD
    } mode_t;

    // Field position tracker states
    typedef enum logic [1:0] {
        ST_BLANK,
        ST_FLD1,
        ST_FLD2
    } fld_state_t;

endpackage

// File: rtl/vdn_mode_decode.sv
module vdn_mode_decode
    import vdn_pkg::*;
(
    input  logic             cont_en,
    input  logic             frame_sel,
    input  logic [SEL_W-1:0] fld_sel,
    output mode_t            mode,
    output logic             show1,
    output logic             show2
);

    always_comb begin
        if (cont_en) begin
            mode = MD_CONT;
        end else if (!frame_sel) begin
            unique case (fld_sel)
                2'b01:   mode = MD_FLD1;
                2'b10:   mode = MD_FLD2;
                2'b11:   mode = MD_BOTH;
                default: mode = MD_RSVD;
            endcase
        end else begin
            unique case (fld_sel)
                2'b00:   mode = MD_FRAME;
                2'b01:   mode = MD_PROG;
                default: mode = MD_RSVD;
            endcase
        end
    end

    // Which fields fetch real data in each operation
    always_comb begin
        unique case (mode)
            MD_CONT:  begin show1 = 1'b1; show2 = 1'b1; end
            MD_FLD1:  begin show1 = 1'b1; show2 = 1'b0; end
            MD_FLD2:  begin show1 = 1'b0; show2 = 1'b1; end
            MD_BOTH:  begin show1 = 1'b1; show2 = 1'b1; end
            MD_FRAME: begin show1 = 1'b1; show2 = 1'b1; end
            MD_PROG:  begin show1 = 1'b1; show2 = 1'b0; end
            default:  begin show1 = 1'b0; show2 = 1'b0; end
        endcase
    end

endmodule

// File: rtl/vdn_field_fsm.sv
module vdn_field_fsm
    import vdn_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic f1_start,
    input  logic f1_end,
    input  logic f2_start,
    input  logic f2_end,
    input  logic show1,
    input  logic show2,
    output logic xfer_en
);

    fld_state_t state_q, state_d;

    // Transitions: start strobes enter a field from any state,
    // end strobes return to blanking; a start outranks an end.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BLANK, ST_FLD1, ST_FLD2: begin
                if (f1_start)
                    state_d = ST_FLD1;
                else if (f2_start)
                    state_d = ST_FLD2;
                else if (f1_end || f2_end)
                    state_d = ST_BLANK;
            end
            default: state_d = ST_BLANK;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_BLANK;
        else
            state_q <= state_d;
    end

    // Output process: default data unless the current field is enabled
    always_comb begin
        unique case (state_q)
            ST_FLD1: xfer_en = show1;
            ST_FLD2: xfer_en = show2;
            default: xfer_en = 1'b0;
        endcase
    end

endmodule

// File: rtl/vdn_flag_bank.sv
module vdn_flag_bank
    import vdn_pkg::*;
#(
    parameter int N = NFLAG
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_ev,
    input  logic [N-1:0] clr_ev,
    input  logic [N-1:0] due_ev,
    output logic [N-1:0] done,
    output logic         cmpl_irq,
    output logic         miss_irq
);

    logic [N-1:0] miss;

    for (genvar i = 0; i < N; i++) begin : g_flag
        logic flag_q;

        // Set takes priority over a same-cycle clear
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                flag_q <= 1'b0;
            else if (set_ev[i])
                flag_q <= 1'b1;
            else if (clr_ev[i])
                flag_q <= 1'b0;
        end

        // Deadline reached while still unacknowledged
        assign miss[i] = due_ev[i] & flag_q & ~clr_ev[i];
        assign done[i] = flag_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmpl_irq <= 1'b0;
            miss_irq <= 1'b0;
        end else begin
            cmpl_irq <= |set_ev;
            miss_irq <= |miss;
        end
    end

endmodule

// File: rtl/vid_done_notify.sv
module vid_done_notify
    import vdn_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cont_en,
    input  logic       frame_sel,
    input  logic [1:0] fld_sel,
    input  logic       f1_start,
    input  logic       f1_end,
    input  logic       f2_start,
    input  logic       f2_end,
    input  logic       ack_f1,
    input  logic       ack_f2,
    input  logic       ack_frm,
    output logic       f1_done,
    output logic       f2_done,
    output logic       frm_done,
    output logic       cmpl_irq,
    output logic       miss_irq,
    output logic       xfer_en
);

    mode_t            mode;
    logic             show1, show2;
    logic [NFLAG-1:0] set_ev, clr_ev, due_ev, done;

    vdn_mode_decode u_dec (
        .cont_en   (cont_en),
        .frame_sel (frame_sel),
        .fld_sel   (fld_sel),
        .mode      (mode),
        .show1     (show1),
        .show2     (show2)
    );

    vdn_field_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .f1_start (f1_start),
        .f1_end   (f1_end),
        .f2_start (f2_start),
        .f2_end   (f2_end),
        .show1    (show1),
        .show2    (show2),
        .xfer_en  (xfer_en)
    );

    // Map strobes to set events and acknowledge deadlines per operation
    always_comb begin
        set_ev = '0;
        due_ev = '0;
        unique case (mode)
            MD_FLD1: begin
                set_ev[IDX_F1] = f1_end;
                due_ev[IDX_F1] = f1_start;
            end
            MD_FLD2: begin
                set_ev[IDX_F2] = f2_end;
                due_ev[IDX_F2] = f2_start;
            end
            MD_BOTH: begin
                set_ev[IDX_F1] = f1_end;
                set_ev[IDX_F2] = f2_end;
                due_ev[IDX_F1] = f1_start;
                due_ev[IDX_F2] = f2_start;
            end
            MD_FRAME: begin
                set_ev[IDX_FRM] = f2_end;
                due_ev[IDX_FRM] = f2_end;
            end
            MD_PROG: begin
                set_ev[IDX_FRM] = f1_end;
                due_ev[IDX_FRM] = f1_end;
            end
            default: begin
                set_ev = '0;
                due_ev = '0;
            end
        endcase
    end

    always_comb begin
        clr_ev          = '0;
        clr_ev[IDX_F1]  = ack_f1;
        clr_ev[IDX_F2]  = ack_f2;
        clr_ev[IDX_FRM] = ack_frm;
    end

    vdn_flag_bank #(.N(NFLAG)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_ev   (set_ev),
        .clr_ev   (clr_ev),
        .due_ev   (due_ev),
        .done     (done),
        .cmpl_irq (cmpl_irq),
        .miss_irq (miss_irq)
    );

    assign f1_done  = done[IDX_F1];
    assign f2_done  = done[IDX_F2];
    assign frm_done = done[IDX_FRM];

endmodule

// File: rtl/vid_done_notify_chk.sv
module vid_done_notify_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cont_en,
    input logic       frame_sel,
    input logic [1:0] fld_sel,
    input logic       f1_start,
    input logic       f1_end,
    input logic       f2_start,
    input logic       f2_end,
    input logic       ack_f1,
    input logic       ack_f2,
    input logic       ack_frm,
    input logic       f1_done,
    input logic       f2_done,
    input logic       frm_done,
    input logic       cmpl_irq,
    input logic       miss_irq,
    input logic       xfer_en
);

    logic rsvd, f1_field_mode, frame_op;
    assign rsvd          = !cont_en && ((!frame_sel && fld_sel == 2'b00) ||
                                        (frame_sel && fld_sel[1]));
    assign f1_field_mode = !cont_en && !frame_sel && fld_sel[0];
    assign frame_op      = !cont_en && frame_sel && fld_sel == 2'b00;

    a_r2_cont_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cont_en |=> (!cmpl_irq && !miss_irq));

    a_r8_rsvd_no_xfer: assert property (@(posedge clk) disable iff (!rst_n)
        rsvd |-> !xfer_en);

    a_r8_rsvd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        rsvd |=> !cmpl_irq);

    a_r9_set_pulses_irq: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(f1_done) || $rose(f2_done) || $rose(frm_done)) |-> cmpl_irq);

    a_r10_field_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (f1_field_mode && f1_start && f1_done && !ack_f1) |=> (miss_irq && f1_done));

    a_r11_frame_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_op && f2_end && frm_done && !ack_frm) |=> (miss_irq && frm_done));

    a_r12_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_f2 && !f2_end) |=> !f2_done);

    a_r12_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (f1_field_mode && f1_end && ack_f1) |=> f1_done);

    a_r13_blank_default: assert property (@(posedge clk) disable iff (!rst_n)
        ((f1_end || f2_end) && !f1_start && !f2_start) |=> !xfer_en);

endmodule

bind vid_done_notify vid_done_notify_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cont_en   (cont_en),
    .frame_sel (frame_sel),
    .fld_sel   (fld_sel),
    .f1_start  (f1_start),
    .f1_end    (f1_end),
    .f2_start  (f2_start),
    .f2_end    (f2_end),
    .ack_f1    (ack_f1),
    .ack_f2    (ack_f2),
    .ack_frm   (ack_frm),
    .f1_done   (f1_done),
    .f2_done   (f2_done),
    .frm_done  (frm_done),
    .cmpl_irq  (cmpl_irq),
    .miss_irq  (miss_irq),
    .xfer_en   (xfer_en)
);

// File: tb/vid_done_notify_test.sv
`timescale 1ns/1ps
module vid_done_notify_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cont_en = 1'b0, frame_sel = 1'b0;
    logic [1:0] fld_sel = 2'b00;
    logic       f1_start = 1'b0, f1_end = 1'b0, f2_start = 1'b0, f2_end = 1'b0;
    logic       ack_f1 = 1'b0, ack_f2 = 1'b0, ack_frm = 1'b0;
    logic       f1_done, f2_done, frm_done, cmpl_irq, miss_irq, xfer_en;

    int  checks = 0;
    int  fails  = 0;
    bit  finished = 1'b0;

    // reference model state
    logic e_f1, e_f2, e_fr;
    int   e_pos;
    int   md;           // 0 cont,1 fld1,2 fld2,3 both,4 frame,5 prog,6 rsvd
    string mtag;

    always #2 clk = ~clk;   // 250 MHz

    vid_done_notify uut (
        .clk(clk), .rst_n(rst_n), .cont_en(cont_en), .frame_sel(frame_sel),
        .fld_sel(fld_sel), .f1_start(f1_start), .f1_end(f1_end),
        .f2_start(f2_start), .f2_end(f2_end), .ack_f1(ack_f1), .ack_f2(ack_f2),
        .ack_frm(ack_frm), .f1_done(f1_done), .f2_done(f2_done),
        .frm_done(frm_done), .cmpl_irq(cmpl_irq), .miss_irq(miss_irq),
        .xfer_en(xfer_en)
    );

    task automatic check(input string req, input string what,
                         input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %b expected %b (mode %0d)", req, what, act, exp, md);
        end
    endtask

    function automatic int classify(input logic c, input logic fr, input logic [1:0] s);
        if (c) return 0;
        if (!fr) return (s == 2'b00) ? 6 : int'(s);
        if (s == 2'b00) return 4;
        if (s == 2'b01) return 5;
        return 6;
    endfunction

    // one stimulus cycle followed by a comparison against the model
    task automatic step(input logic s1, input logic e1, input logic s2, input logic e2,
                        input logic c1, input logic c2, input logic cf);
        logic set1, set2, setf, due1, due2, duef, x_miss, x_cmpl, d1, d2, x_xfer;
        f1_start = s1; f1_end = e1; f2_start = s2; f2_end = e2;
        ack_f1 = c1; ack_f2 = c2; ack_frm = cf;
        set1 = e1 && (md == 1 || md == 3);
        set2 = e2 && (md == 2 || md == 3);
        setf = (e2 && md == 4) || (e1 && md == 5);
        due1 = s1 && (md == 1 || md == 3) && e_f1 && !c1;
        due2 = s2 && (md == 2 || md == 3) && e_f2 && !c2;
        duef = setf && e_fr && !cf;
        x_miss = due1 || due2 || duef;
        x_cmpl = set1 || set2 || setf;
        e_f1 = set1 ? 1'b1 : (c1 ? 1'b0 : e_f1);
        e_f2 = set2 ? 1'b1 : (c2 ? 1'b0 : e_f2);
        e_fr = setf ? 1'b1 : (cf ? 1'b0 : e_fr);
        if (s1) e_pos = 1; else if (s2) e_pos = 2; else if (e1 || e2) e_pos = 0;
        d1 = (md == 0 || md == 1 || md == 3 || md == 4 || md == 5);
        d2 = (md == 0 || md == 2 || md == 3 || md == 4);
        x_xfer = (e_pos == 1 && d1) || (e_pos == 2 && d2);
        @(negedge clk);
        f1_start = 0; f1_end = 0; f2_start = 0; f2_end = 0;
        ack_f1 = 0; ack_f2 = 0; ack_frm = 0;
        check(mtag,  "f1_done",  f1_done,  e_f1);
        check(mtag,  "f2_done",  f2_done,  e_f2);
        check(mtag,  "frm_done", frm_done, e_fr);
        check("R9",  "cmpl_irq", cmpl_irq, x_cmpl);
        check((md >= 4 && md != 6) ? "R11" : "R10", "miss_irq", miss_irq, x_miss);
        check("R13", "xfer_en",  xfer_en,  x_xfer);
    endtask

    initial begin
        #100000;
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 16; k++) begin
            rst_n = 1'b0;
            e_f1 = 0; e_f2 = 0; e_fr = 0; e_pos = 0;
            cont_en = k[3]; frame_sel = k[2]; fld_sel = k[1:0];
            md = classify(cont_en, frame_sel, fld_sel);
            case (md)
                0: mtag = "R2";
                1: mtag = "R3";
                2: mtag = "R4";
                3: mtag = "R5";
                4: mtag = "R6";
                5: mtag = "R7";
                default: mtag = "R8";
            endcase
            repeat (2) @(negedge clk);
            if (k == 0) begin
                check("R1", "f1_done in reset", f1_done, 1'b0);
                check("R1", "f2_done in reset", f2_done, 1'b0);
                check("R1", "frm_done in reset", frm_done, 1'b0);
                check("R1", "cmpl_irq in reset", cmpl_irq, 1'b0);
                check("R1", "miss_irq in reset", miss_irq, 1'b0);
            end
            rst_n = 1'b1;
            @(negedge clk);
            check("R1", "xfer_en after reset", xfer_en, 1'b0);
            check("R1", "f1_done after reset", f1_done, 1'b0);
            // first frame
            step(1,0,0,0, 0,0,0);
            step(0,0,0,0, 0,0,0);
            step(0,1,0,0, 0,0,0);
            step(0,0,1,0, 0,0,0);
            step(0,0,0,1, 0,0,0);
            // second frame, nothing acknowledged
            step(1,0,0,0, 0,0,0);
            step(0,1,0,0, 0,0,0);
            step(0,0,1,0, 0,0,0);
            step(0,0,0,1, 0,0,0);
            // clears colliding with deadlines and with sets (R12)
            step(1,0,0,0, 1,0,0);
            step(0,1,0,0, 1,0,1);
            step(0,0,1,0, 0,1,0);
            step(0,0,0,1, 0,1,1);
            step(0,0,0,0, 1,1,1);
            step(0,0,0,0, 0,0,0);
        end
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule